// File: doc/BRIEF.md
# DMA Page Register Address Generator

This block keeps the page bytes that extend a DMA controller's 16-bit channel address into a wide physical bus address. There are four channels, each with a low page byte and a high page byte. Software reaches them through a byte-wide I/O window of eight port offsets per bank. A fixed, non-linear table maps each offset to a channel, and offsets that map to no channel are holes.

The channel logic supplies the active channel number and that channel's current 16-bit address. From these the block forms the physical address, with the high page byte cut to its lower seven bits. It also forms the byte address for a transfer at a given position. In increment mode it counts up from the physical address. In decrement mode it counts down and leaves room for the whole block, because the data of a decrementing block is laid out backwards below the base. A parameter can remove the high page bank at elaboration.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset every page byte of both banks reads 0, and physAddr equals curAddr zero-extended.
- R2: Port offset bits [2:0] select the channel: offset 1 is channel 2, offset 2 is channel 3, offset 3 is channel 1 and offset 7 is channel 0. bankSel=0 addresses the low page bank and bankSel=1 the high page bank.
- R3: A write to offset 0, 4, 5 or 6 changes no page byte, and a read from any of these offsets returns 0.
- R4: The low and high banks are separate storage. A write to one bank leaves the other unchanged, and a write to one channel leaves the other channels unchanged.
- R5: physAddr = {highPage[actCh][6:0], lowPage[actCh][7:0], curAddr[15:0]}, a 31-bit value. Bit 7 of the high page byte is stored and read back, but it does not reach the address.
- R6: With decMode=0, xferAddr = physAddr + xferPos modulo 2^31.
- R7: With decMode=1, xferAddr = physAddr - xferPos - xferLen modulo 2^31.
- R8: A write takes effect at the rising clock edge where wrEn is high. rdData follows portOfs and bankSel within the same cycle, and physAddr and xferAddr follow their inputs within the same cycle.
- R9: With HAS_HIGH=0, high-bank writes are dropped, high-bank reads return 0, and physAddr[30:24] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Byte write strobe |
| bankSel | input | 1 | 0 = low page bank, 1 = high page bank |
| portOfs | input | 3 | Port offset within the window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed page byte |
| actCh | input | 2 | Active channel |
| curAddr | input | 16 | Current channel address |
| decMode | input | 1 | 1 = decrementing transfer |
| xferPos | input | 16 | Byte position within the transfer |
| xferLen | input | 16 | Block length (decrement mode) |
| physAddr | output | 31 | Composed physical address |
| xferAddr | output | 31 | Byte address for the given position |

## Verification
A page write is due one edge after wrEn is sampled high. Every other result is combinational and is due in the same cycle as its inputs. The bench therefore changes inputs only at falling edges. After a write it compares a readback at the next falling edge. For address results it compares shortly after the falling edge at which the operands were driven. A second instance built without the high bank runs alongside and checks the reduced variant under the same stimulus.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
    logic            wrLow;
    logic            wrHigh;
    logic            rdHigh;
  } pageStrobe_t;

  // fixed, non-linear offset to channel table; returns {hit, ch}
  function automatic logic [CH_W:0] portToChan(input logic [2:0] ofs);
    case (ofs)
      3'd1:    portToChan = {1'b1, 2'd2};
      3'd2:    portToChan = {1'b1, 2'd3};
      3'd3:    portToChan = {1'b1, 2'd1};
      3'd7:    portToChan = {1'b1, 2'd0};
      default: portToChan = '0;
    endcase
  endfunction
endpackage

// File: rtl/dma_page_ctrl.sv
module dma_page_ctrl
  import dma_page_pkg::*;
#(
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic        wrEn,
  input  logic        bankSel,
  input  logic [2:0]  portOfs,
  output pageStrobe_t strb
);
  logic [CH_W:0] lookup;

  always_comb begin
    lookup      = portToChan(portOfs);
    strb.hit    = lookup[CH_W];
    strb.ch     = lookup[CH_W-1:0];
    strb.wrLow  = wrEn && lookup[CH_W] && !bankSel;
    strb.wrHigh = HAS_HIGH && wrEn && lookup[CH_W] && bankSel;
    strb.rdHigh = bankSel;
  end
endmodule

// File: rtl/dma_page_dp.sv
module dma_page_dp
  import dma_page_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int HIGH_BITS = 7,
  parameter int ADDR_W    = 16,
  parameter bit HAS_HIGH  = 1'b1,
  localparam int PHYS_W   = HIGH_BITS + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pageStrobe_t       strb,
  input  logic [PAGE_W-1:0] wrData,
  input  logic [CH_W-1:0]   actCh,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              decMode,
  input  logic [ADDR_W-1:0] xferPos,
  input  logic [ADDR_W-1:0] xferLen,
  output logic [PAGE_W-1:0] rdData,
  output logic [PHYS_W-1:0] physAddr,
  output logic [PHYS_W-1:0] xferAddr
);
  logic [PAGE_W-1:0] lowPage  [NUM_CH];
  logic [PAGE_W-1:0] highPage [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) lowPage[i] <= '0;
    end else if (strb.wrLow) begin
      lowPage[strb.ch] <= wrData;
    end
  end

  generate
    if (HAS_HIGH) begin : gHigh
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < NUM_CH; i++) highPage[i] <= '0;
        end else if (strb.wrHigh) begin
          highPage[strb.ch] <= wrData;
        end
      end
    end else begin : gNoHigh
      always_comb begin
        for (int i = 0; i < NUM_CH; i++) highPage[i] = '0;
      end
    end
  endgenerate

  always_comb begin
    if (!strb.hit)       rdData = '0;
    else if (strb.rdHigh) rdData = highPage[strb.ch];
    else                 rdData = lowPage[strb.ch];
  end

  logic [HIGH_BITS-1:0] highCut;
  logic [PHYS_W-1:0]    posExt, lenExt;

  always_comb begin
    highCut  = highPage[actCh][HIGH_BITS-1:0];
    physAddr = {highCut, lowPage[actCh], curAddr};
    posExt   = PHYS_W'(xferPos);
    lenExt   = PHYS_W'(xferLen);
    if (decMode) xferAddr = physAddr - posExt - lenExt;
    else         xferAddr = physAddr + posExt;
  end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_page_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int HIGH_BITS = 7,
  parameter int ADDR_W    = 16,
  parameter bit HAS_HIGH  = 1'b1,
  localparam int PHYS_W   = HIGH_BITS + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              bankSel,
  input  logic [2:0]        portOfs,
  input  logic [PAGE_W-1:0] wrData,
  output logic [PAGE_W-1:0] rdData,
  input  logic [CH_W-1:0]   actCh,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              decMode,
  input  logic [ADDR_W-1:0] xferPos,
  input  logic [ADDR_W-1:0] xferLen,
  output logic [PHYS_W-1:0] physAddr,
  output logic [PHYS_W-1:0] xferAddr
);
  pageStrobe_t strb;

  dma_page_ctrl #(.HAS_HIGH(HAS_HIGH)) uCtrl (
    .wrEn(wrEn), .bankSel(bankSel), .portOfs(portOfs), .strb(strb)
  );

  dma_page_dp #(
    .PAGE_W(PAGE_W), .HIGH_BITS(HIGH_BITS), .ADDR_W(ADDR_W), .HAS_HIGH(HAS_HIGH)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .actCh(actCh), .curAddr(curAddr), .decMode(decMode),
    .xferPos(xferPos), .xferLen(xferLen),
    .rdData(rdData), .physAddr(physAddr), .xferAddr(xferAddr)
  );
endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk
  import dma_page_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int HIGH_BITS = 7,
  parameter int ADDR_W    = 16,
  parameter bit HAS_HIGH  = 1'b1,
  localparam int PHYS_W   = HIGH_BITS + PAGE_W + ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              bankSel,
  input logic [2:0]        portOfs,
  input logic [PAGE_W-1:0] wrData,
  input logic [PAGE_W-1:0] rdData,
  input logic [CH_W-1:0]   actCh,
  input logic [ADDR_W-1:0] curAddr,
  input logic              decMode,
  input logic [ADDR_W-1:0] xferPos,
  input logic [ADDR_W-1:0] xferLen,
  input logic [PHYS_W-1:0] physAddr,
  input logic [PHYS_W-1:0] xferAddr
);
  logic isHole;
  assign isHole = (portOfs == 3'd0) || (portOfs == 3'd4) ||
                  (portOfs == 3'd5) || (portOfs == 3'd6);

  // R3
  a_r3_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    isHole |-> rdData == '0);

  // R5
  a_r5_low_bits_pass: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[ADDR_W-1:0] == curAddr);

  // R6
  a_r6_inc_offset: assert property (@(posedge clk) disable iff (!rstN)
    !decMode |-> (xferAddr - physAddr) == PHYS_W'(xferPos));

  // R7
  a_r7_dec_offset: assert property (@(posedge clk) disable iff (!rstN)
    decMode |-> (physAddr - xferAddr) == PHYS_W'(xferPos) + PHYS_W'(xferLen));

  // R8: without a write, the page part of the address holds for a fixed channel
  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn ##1 $stable(actCh)) |-> $stable(physAddr[PHYS_W-1:ADDR_W]));

  // R9
  a_r9_no_high_bank: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_HIGH |-> physAddr[PHYS_W-1:PAGE_W+ADDR_W] == '0);
endmodule

bind dma_page_addr_gen dma_page_addr_chk #(
  .PAGE_W(PAGE_W), .HIGH_BITS(HIGH_BITS), .ADDR_W(ADDR_W), .HAS_HIGH(HAS_HIGH)
) uChk (.*);

// File: tb/tb_dma_page_addr_gen.sv
module tb_dma_page_addr_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, bankSel = 1'b0, decMode = 1'b0;
  logic [2:0] portOfs = '0;
  logic [7:0] wrData = '0;
  logic [1:0] actCh = '0;
  logic [15:0] curAddr = '0, xferPos = '0, xferLen = '0;
  logic [7:0] rdData, rdDataLo;
  logic [30:0] physAddr, xferAddr, physAddrLo, xferAddrLo;

  int total = 0;
  int bad = 0;
  logic [7:0] lowM [4];
  logic [7:0] highM [4];

  always #10 clk = ~clk;

  dma_page_addr_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .bankSel(bankSel), .portOfs(portOfs),
    .wrData(wrData), .rdData(rdData), .actCh(actCh), .curAddr(curAddr),
    .decMode(decMode), .xferPos(xferPos), .xferLen(xferLen),
    .physAddr(physAddr), .xferAddr(xferAddr)
  );

  dma_page_addr_gen #(.HAS_HIGH(1'b0)) dutLo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .bankSel(bankSel), .portOfs(portOfs),
    .wrData(wrData), .rdData(rdDataLo), .actCh(actCh), .curAddr(curAddr),
    .decMode(decMode), .xferPos(xferPos), .xferLen(xferLen),
    .physAddr(physAddrLo), .xferAddr(xferAddrLo)
  );

  function automatic int chanOf(input logic [2:0] ofs);
    case (ofs)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 1;
      3'd7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [30:0] expPhys(input int ch, input logic [15:0] cur, input bit withHigh);
    logic [6:0] h;
    h = withHigh ? highM[ch][6:0] : 7'd0;
    return {h, lowM[ch], cur};
  endfunction

  function automatic logic [30:0] expXfer(input logic [30:0] p, input bit dec,
                                          input logic [15:0] pos, input logic [15:0] len);
    if (dec) return p - 31'(pos) - 31'(len);
    return p + 31'(pos);
  endfunction

  function automatic logic [7:0] expRead(input bit bank, input logic [2:0] ofs, input bit withHigh);
    int c;
    c = chanOf(ofs);
    if (c < 0) return 8'h00;
    if (bank) return withHigh ? highM[c] : 8'h00;
    return lowM[c];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input bit bank, input logic [2:0] ofs, input logic [7:0] d);
    int c;
    @(negedge clk);
    wrEn = 1'b1; bankSel = bank; portOfs = ofs; wrData = d;
    @(posedge clk);
    #1;
    c = chanOf(ofs);
    if (c >= 0) begin
      if (bank) highM[c] = d; else lowM[c] = d;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkRead(input string req, input bit bank, input logic [2:0] ofs);
    @(negedge clk);
    bankSel = bank; portOfs = ofs;
    #2;
    check(req, 32'(rdData), 32'(expRead(bank, ofs, 1'b1)));
    check({req, " R9"}, 32'(rdDataLo), 32'(expRead(bank, ofs, 1'b0)));
  endtask

  task automatic checkAll(input string req);
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 8; o++) checkRead(req, b[0], o[2:0]);
  endtask

  task automatic checkAddr(input string req, input logic [1:0] ch, input logic [15:0] cur,
                           input bit dec, input logic [15:0] pos, input logic [15:0] len);
    logic [30:0] p;
    @(negedge clk);
    actCh = ch; curAddr = cur; decMode = dec; xferPos = pos; xferLen = len;
    #2;
    p = expPhys(int'(ch), cur, 1'b1);
    check({req, " phys R5"}, 32'(physAddr), 32'(p));
    check({req, dec ? " xfer R7" : " xfer R6"}, 32'(xferAddr), 32'(expXfer(p, dec, pos, len)));
    p = expPhys(int'(ch), cur, 1'b0);
    check({req, " phys R9"}, 32'(physAddrLo), 32'(p));
    check({req, " xfer R9"}, 32'(xferAddrLo), 32'(expXfer(p, dec, pos, len)));
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 4; i++) begin lowM[i] = '0; highM[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkAll("R1 reset");
    checkAddr("R1 reset", 2'd1, 16'h1234, 1'b0, 16'd0, 16'd0);

    // R2/R4: mapping through the table, banks separate
    doWrite(1'b0, 3'd7, 8'hA5);
    doWrite(1'b0, 3'd1, 8'h22);
    doWrite(1'b0, 3'd2, 8'h33);
    doWrite(1'b0, 3'd3, 8'h11);
    checkAll("R2 low map");
    doWrite(1'b1, 3'd3, 8'hFF);
    checkAll("R4 high sep");
    // R5: bit 7 of high page dropped from address
    checkAddr("R5 ch1", 2'd1, 16'hBEEF, 1'b0, 16'd5, 16'd0);
    checkAddr("R2 ch0", 2'd0, 16'h0001, 1'b0, 16'd0, 16'd0);

    // R8: write visible at next edge, not before
    @(negedge clk);
    wrEn = 1'b1; bankSel = 1'b0; portOfs = 3'd7; wrData = 8'h5A; actCh = 2'd0;
    #2;
    check("R8 before edge", 32'(rdData), 32'h000000A5);
    @(posedge clk); #1; lowM[0] = 8'h5A;
    check("R8 after edge", 32'(rdData), 32'h0000005A);
    @(negedge clk); wrEn = 1'b0;

    // R3: hole writes dropped
    for (int o = 0; o < 8; o++)
      if (chanOf(o[2:0]) < 0) begin
        doWrite(1'b0, o[2:0], 8'hC3);
        doWrite(1'b1, o[2:0], 8'h3C);
      end
    checkAll("R3 holes");

    // R7: decrement wrap below zero
    doWrite(1'b0, 3'd2, 8'h00);
    doWrite(1'b1, 3'd2, 8'h00);
    checkAddr("R7 wrap", 2'd3, 16'h0004, 1'b1, 16'h0010, 16'h0100);
    // R6: increment wrap at top
    doWrite(1'b0, 3'd1, 8'hFF);
    doWrite(1'b1, 3'd1, 8'h7F);
    checkAddr("R6 wrap", 2'd2, 16'hFFFF, 1'b0, 16'hFFFF, 16'h0000);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 3;
      if (op == 0)
        doWrite(1'($urandom), 3'($urandom), 8'($urandom));
      else if (op == 1)
        checkRead("R2 rand read", 1'($urandom), 3'($urandom));
      else
        checkAddr("rand", 2'($urandom), 16'($urandom), 1'($urandom),
                  16'($urandom), 16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule